// File: doc/BRIEF.md
# Pin Change Interrupt Unit with Hold Mode

This unit watches a bank of general-purpose input pins and pulls an active-low interrupt line when an enabled pin changes level. Each pin is compared against a stored reference level. The unit loads that reference at reset, and again each time the input-port register is read.

Each pin works in one of two modes. In track mode the status bit follows the difference between the pin and its reference, so a pulse that returns before the read disappears by itself. In hold mode the first changed level is captured and kept. The status bit then stays set until a read, and the read returns the captured level instead of the live one.

Configuration comes in as two vectors: an enable mask and a per-pin mode select. A one-cycle strobe marks each read of the input-port register. The unit drives the port value that such a read returns, the per-pin status vector and the interrupt line.

Top module: `pchg_irq_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `irq_status` is 0 and `irq_n` is 1. Once the pins have been stable through reset, `port_value` equals the pin levels.
- R2: An unmasked pin in track mode (its `cfg_hold` bit 0) that changes level in either direction sets bit i of `irq_status`, where i is the pin index. The bit is visible after the third rising edge that follows the change at the pin.
- R3: A pin whose `cfg_mask` bit is 1 never sets its status bit and never lowers `irq_n`. Its level still appears on `port_value`.
- R4: In track mode, if a pin returns to its reference level before a read, its status bit clears by itself three edges after the return.
- R5: In hold mode (`cfg_hold` bit 1), a change sets the status bit. The bit then stays set, and `irq_n` stays low, until a read, even if the pin returns to its earlier level.
- R6: In hold mode, while the status bit is set, `port_value` bit i shows the captured changed level rather than the live pin. After the read it shows the live level again.
- R7: In hold mode, a pin that returns to its earlier level before the read raises no new interrupt after the read.
- R8: In hold mode, if the read comes first and the pin then returns to its earlier level, the return raises a new interrupt.
- R9: Several status bits can be set together. Status bits persist with no read, and only `rd_strobe` clears them.
- R10: In the cycle after `rd_strobe`, `irq_status` is 0, because every reference is reloaded with the live synchronized level.
- R11: A change that reaches the synchronizer output on the same edge that consumes `rd_strobe` is not part of the value read. Its status bit is set one cycle later.
- R12: `irq_n` is a register that is low exactly when `irq_status` is non-zero, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_async | input | PINS | Raw input pins, asynchronous |
| cfg_mask | input | PINS | 1 masks a pin from the interrupt, 0 enables it |
| cfg_hold | input | PINS | 1 selects hold mode, 0 selects track mode |
| rd_strobe | input | 1 | One-cycle pulse marking a read of the input-port register |
| port_value | output | PINS | Value returned by an input-port read |
| irq_status | output | PINS | Per-pin interrupt cause, registered |
| irq_n | output | 1 | Active-low interrupt, registered |

## Verification
The hold-mode assertions assume that `cfg_mask` and `cfg_hold` stay stable around the cycles they examine. They also assume that no read comes in between. The properties are gated on exactly those conditions, and the bench changes configuration only while no hold-mode capture is pending. Pins are driven on falling edges and held for at least three clock cycles, so every change passes cleanly through the synchronizer. The one exception is the R11 sequence, which places a change exactly at the edge where the read strobe is consumed.

// File: rtl/pchg_pkg.sv
package pchg_pkg;

  typedef enum logic {
    MODE_TRACK = 1'b0,
    MODE_HOLD  = 1'b1
  } pin_mode_e;

  typedef struct packed {
    logic      masked;
    pin_mode_e mode;
  } pin_cfg_t;

  localparam int unsigned SYNC_DEPTH_MIN = 2;

endpackage

// File: rtl/pchg_sync.sv
module pchg_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    chain[0] <= d_async;
    for (int k = 1; k < STAGES; k++) begin
      chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pchg_pin_track.sv
module pchg_pin_track
  import pchg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     lvl,
  input  logic     rd,
  input  pin_cfg_t cfg,
  output logic     stat_d,
  output logic     stat_q,
  output logic     rd_val
);

  logic ref_q;
  logic cap_q;
  logic held_q;
  logic held_d;
  logic diff;

  assign diff = lvl ^ ref_q;

  always_comb begin
    held_d = 1'b0;
    if (!rd && cfg.mode == MODE_HOLD && !cfg.masked) begin
      held_d = held_q | diff;
    end
    if (cfg.mode == MODE_HOLD) begin
      stat_d = held_d;
    end else begin
      stat_d = !rd && !cfg.masked && diff;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= lvl;
      cap_q  <= lvl;
      held_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (rd) begin
        ref_q <= lvl;
      end
      if (!held_q) begin
        cap_q <= lvl;
      end
      held_q <= held_d;
      stat_q <= stat_d;
    end
  end

  assign rd_val = held_q ? cap_q : lvl;

endmodule

// File: rtl/pchg_irq_merge.sv
module pchg_irq_merge #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat_d,
  output logic         irq_n
);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n <= 1'b1;
    end else begin
      irq_n <= ~|stat_d;
    end
  end

endmodule

// File: rtl/pchg_irq_unit.sv
module pchg_irq_unit
  import pchg_pkg::*;
#(
  parameter int unsigned PINS        = 8,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH_MIN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pins_async,
  input  logic [PINS-1:0] cfg_mask,
  input  logic [PINS-1:0] cfg_hold,
  input  logic            rd_strobe,
  output logic [PINS-1:0] port_value,
  output logic [PINS-1:0] irq_status,
  output logic            irq_n
);

  logic [PINS-1:0] lvl_sync;
  logic [PINS-1:0] stat_next;

  pchg_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .d_async (pins_async),
    .q       (lvl_sync)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    pin_cfg_t cfg_i;
    assign cfg_i.masked = cfg_mask[i];
    assign cfg_i.mode   = cfg_hold[i] ? MODE_HOLD : MODE_TRACK;

    pchg_pin_track u_track (
      .clk    (clk),
      .rst    (rst),
      .lvl    (lvl_sync[i]),
      .rd     (rd_strobe),
      .cfg    (cfg_i),
      .stat_d (stat_next[i]),
      .stat_q (irq_status[i]),
      .rd_val (port_value[i])
    );
  end

  pchg_irq_merge #(.W(PINS)) u_merge (
    .clk    (clk),
    .rst    (rst),
    .stat_d (stat_next),
    .irq_n  (irq_n)
  );

endmodule

// File: rtl/pchg_irq_unit_chk.sv
module pchg_irq_unit_chk #(
  parameter int unsigned PINS = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [PINS-1:0] cfg_mask,
  input logic [PINS-1:0] cfg_hold,
  input logic            rd_strobe,
  input logic [PINS-1:0] port_value,
  input logic [PINS-1:0] irq_status,
  input logic            irq_n
);

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_n == (irq_status == '0)); // R12

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (irq_status & $past(cfg_mask)) == '0); // R3

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> irq_status == '0); // R10

  AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!rd_strobe && $stable(cfg_hold) && $stable(cfg_mask)) |=>
      (($past(irq_status & cfg_hold & ~cfg_mask) & ~irq_status) == '0)); // R5

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!rd_strobe && $stable(cfg_hold) && $stable(cfg_mask)) |=>
      ((($past(port_value) ^ port_value) & $past(irq_status & cfg_hold & ~cfg_mask)) == '0)); // R6

endmodule

bind pchg_irq_unit pchg_irq_unit_chk #(.PINS(PINS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_mask   (cfg_mask),
  .cfg_hold   (cfg_hold),
  .rd_strobe  (rd_strobe),
  .port_value (port_value),
  .irq_status (irq_status),
  .irq_n      (irq_n)
);

// File: tb/tb_pchg_irq_unit.sv
`timescale 1ns/1ps
module tb_pchg_irq_unit;

  localparam int unsigned PINS = 8;

  logic            clk = 1'b0;
  logic            rst;
  logic [PINS-1:0] pins_async;
  logic [PINS-1:0] cfg_mask;
  logic [PINS-1:0] cfg_hold;
  logic            rd_strobe;
  logic [PINS-1:0] port_value;
  logic [PINS-1:0] irq_status;
  logic            irq_n;

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  pchg_irq_unit #(.PINS(PINS)) dut (
    .clk        (clk),
    .rst        (rst),
    .pins_async (pins_async),
    .cfg_mask   (cfg_mask),
    .cfg_hold   (cfg_hold),
    .rd_strobe  (rd_strobe),
    .port_value (port_value),
    .irq_status (irq_status),
    .irq_n      (irq_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    rd_strobe = 1'b1;
    tick(1);
    rd_strobe = 1'b0;
  endtask

  initial begin
    logic [PINS-1:0] pv;
    logic [PINS-1:0] old;
    rst = 1'b1; pv = 8'hA5; pins_async = pv;
    cfg_mask = '1; cfg_hold = '0; rd_strobe = 1'b0;
    tick(5);
    rst = 1'b0;
    tick(1);
    chk("R1 status", irq_status, 0);
    chk("R1 irq_n", irq_n, 1);
    chk("R1 port", port_value, pv);

    cfg_mask = '0;
    tick(3);
    chk("R2 idle status", irq_status, 0);

    // track mode: every pin, both edge directions thanks to mixed levels
    for (int i = 0; i < PINS; i++) begin
      pv ^= (8'h1 << i); pins_async = pv;
      tick(3);
      chk("R2 status", irq_status, 8'h1 << i);
      chk("R12 irq low", irq_n, 0);
      pv ^= (8'h1 << i); pins_async = pv;
      tick(3);
      chk("R4 self clear", irq_status, 0);
      chk("R12 irq high", irq_n, 1);
    end

    // masked pins
    cfg_mask = '1;
    pv ^= 8'hFF; pins_async = pv;
    tick(4);
    chk("R3 status", irq_status, 0);
    chk("R3 irq_n", irq_n, 1);
    chk("R3 port", port_value, pv);
    pv ^= 8'hFF; pins_async = pv;
    tick(3);
    cfg_mask = '0;
    tick(2);
    chk("R3 unmask", irq_status, 0);

    // hold mode sweep
    cfg_hold = '1;
    tick(1);
    for (int i = 0; i < PINS; i++) begin
      pv ^= (8'h1 << i); pins_async = pv;
      tick(3);
      chk("R5 set", irq_status, 8'h1 << i);
      pv ^= (8'h1 << i); pins_async = pv;
      tick(3);
      chk("R5 held", irq_status, 8'h1 << i);
      chk("R5 irq held", irq_n, 0);
      chk("R6 captured", port_value, pv ^ (8'h1 << i));
      do_read();
      chk("R10 cleared", irq_status, 0);
      tick(3);
      chk("R7 no new irq", irq_status, 0);
      chk("R6 live again", port_value, pv);
      pv ^= (8'h1 << i); pins_async = pv;
      tick(3);
      chk("R5 set again", irq_status, 8'h1 << i);
      do_read();
      tick(2);
      chk("R10 after read", irq_status, 0);
      chk("R6 port live", port_value, pv);
      pv ^= (8'h1 << i); pins_async = pv;
      tick(3);
      chk("R8 return irq", irq_status, 8'h1 << i);
      chk("R8 irq_n", irq_n, 0);
      do_read();
      tick(1);
    end

    // several bits together, persistent without read
    cfg_hold = '0;
    tick(1);
    pv ^= 8'h49; pins_async = pv;
    tick(3);
    chk("R9 multi", irq_status, 8'h49);
    tick(5);
    chk("R9 persist", irq_status, 8'h49);
    do_read();
    chk("R10 multi clear", irq_status, 0);

    // change arriving with the read
    tick(2);
    old = pv;
    pv ^= 8'h02; pins_async = pv;
    tick(1);
    chk("R11 old value", port_value, old);
    do_read();
    chk("R11 read cycle", irq_status, 0);
    tick(1);
    chk("R11 next cycle", irq_status, 8'h02);
    do_read();
    tick(1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule